// File: doc/BRIEF.md
# Button Click Classifier

This block watches one already-debounced push-button level and sorts a press into one of four outcomes: nothing pressed, a single click, a double click, or a long hold. A caller pulses a start strobe together with a hold duration in milliseconds; the block answers with a one-clock done pulse and a 3-bit result code that stays on the output until the next answer.

Time is measured on a free-running tick count that advances once every `PRESCALE` master clocks (1024 by default, i.e. 46.875 kHz from 48 MHz). At start the block records a target tick: the current count plus the hold window. In the full click mode a release turns that same reference into a second, fixed post-release window (500 ms by default) in which a new press means a double click. In the held-only mode a release before expiry means a single click right away. Expiry is detected by exact equality between the wrapping count and the stored target.

Top module: `btn_click_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `result_o` is 0 until the first start is accepted.
- R2: The count advances by exactly one every `PRESCALE` clocks. The hold window in ticks is `(TICK_NUM * ms) >> TICK_SHIFT` truncated to `CNT_W` bits; a `hold_ms_i` of 0 selects `DEFAULT_MS`.
- R3: A start sampled while idle with the button released (`btn_i` = 0) gives `done_o` = 1 in the next cycle with result code 0 (no click).
- R4: In click mode (`mode_held_i` = 0 at start), if the button is still pressed on the clock where the count equals the target, the next cycle shows done with code 3 (hold).
- R5: In click mode, a release replaces the target by the current count plus `(TICK_NUM * GAP_MS) >> TICK_SHIFT`; if that target is reached with the button still released, the result is code 1 (single).
- R6: In click mode, a press sampled during the post-release window gives done with code 2 (double) in the next cycle.
- R7: In held-only mode (`mode_held_i` = 1 at start), a release sampled before expiry gives code 1 in the next cycle; reaching the target still pressed gives code 3.
- R8: A start strobe while a classification is in progress is ignored: it neither ends nor restarts it, and the mode and duration latched at the accepted start stay in force.
- R9: The timeout compares the `CNT_W`-bit count with the target modulo 2^`CNT_W`, so windows that straddle the count's wrap end after the same number of ticks.
- R10: `done_o` is a single-cycle pulse per classification and the block is idle in that cycle; `result_o` changes only together with `done_o`. Code 7 is reserved for a corrupted internal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| start_i | input | 1 | Start a classification (sampled when idle) |
| mode_held_i | input | 1 | 0 = click mode, 1 = held-only mode, latched at start |
| hold_ms_i | input | MS_W | Hold duration in ms, 0 = default, latched at start |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| result_o | output | 3 | 0 none, 1 single, 2 double, 3 hold, 7 error |

## Verification
The assertions check on every cycle that the count only steps by one and wraps cleanly, that a start with the button up answers no-click one cycle later, that a press in the post-release window and a release in held-only mode answer at once with the right code, and that results change only with a done pulse from an idle block. The exact cycle at which a hold or single-click window expires, the default duration, the way an extra start during a classification is ignored, and windows that straddle the count's wrap can only be shown by the bench's scenarios against its cycle-level model.

// File: rtl/btn_cls_pkg.sv
package btn_cls_pkg;

    typedef enum logic [2:0] {
        RES_NONE   = 3'd0,
        RES_SINGLE = 3'd1,
        RES_DOUBLE = 3'd2,
        RES_HOLD   = 3'd3,
        RES_ERR    = 3'd7
    } result_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRESS = 2'd1,
        PH_GAP   = 2'd2
    } phase_e;

    // Window length in ticks for a duration in ms: (num * ms) >> shift.
    function automatic logic [63:0] ms_to_ticks(input logic [31:0] num,
                                                 input int          shift,
                                                 input logic [31:0] ms);
        logic [63:0] prod;
        prod = 64'(num) * 64'(ms);
        return prod >> shift;
    endfunction

endpackage

// File: rtl/btn_cls_timebase.sv
module btn_cls_timebase #(
    parameter int PRESCALE = 1024,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] tick_cnt_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t tb_d, tb_q;
    logic      step;

    if (PRESCALE == 1) begin : g_nodiv
        assign step = 1'b1;
    end else begin : g_div
        assign step = (tb_q.pre == PRE_W'(PRESCALE - 1));
    end

    always_comb begin
        tb_d = tb_q;
        if (step) begin
            tb_d.pre = '0;
            tb_d.cnt = tb_q.cnt + 1'b1;
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tick_cnt_o = tb_q.cnt;
endmodule

// File: rtl/btn_cls_window.sv
module btn_cls_window
    import btn_cls_pkg::*;
#(
    parameter int TICK_NUM   = 48000,
    parameter int TICK_SHIFT = 10,
    parameter int DEFAULT_MS = 1000,
    parameter int GAP_MS     = 500,
    parameter int MS_W       = 16,
    parameter int CNT_W      = 16
) (
    input  logic [MS_W-1:0]  hold_ms_i,
    output logic [CNT_W-1:0] hold_ticks_o,
    output logic [CNT_W-1:0] gap_ticks_o
);
    localparam logic [CNT_W-1:0] GAP_TICKS =
        CNT_W'(ms_to_ticks(32'(TICK_NUM), TICK_SHIFT, 32'(GAP_MS)));

    logic [31:0] ms_eff;

    always_comb begin
        if (hold_ms_i == '0) ms_eff = 32'(DEFAULT_MS);
        else                 ms_eff = 32'(hold_ms_i);
    end

    assign hold_ticks_o = CNT_W'(ms_to_ticks(32'(TICK_NUM), TICK_SHIFT, ms_eff));
    assign gap_ticks_o  = GAP_TICKS;
endmodule

// File: rtl/btn_cls_fsm.sv
module btn_cls_fsm
    import btn_cls_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             btn_i,
    input  logic             mode_held_i,
    input  logic [CNT_W-1:0] hold_ticks_i,
    input  logic [CNT_W-1:0] gap_ticks_i,
    input  logic [CNT_W-1:0] tick_cnt_i,
    output logic             done_o,
    output logic [2:0]       result_o,
    output logic             busy_o,
    output logic             gap_o,
    output logic             held_mode_o
);
    typedef struct packed {
        phase_e           phase;
        logic             held;
        logic [CNT_W-1:0] target;
        logic             done;
        result_e          res;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic       expired;

    assign expired = (tick_cnt_i == st_q.target);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (!btn_i) begin
                        st_d.done = 1'b1;
                        st_d.res  = RES_NONE;
                    end else begin
                        st_d.phase  = PH_PRESS;
                        st_d.held   = mode_held_i;
                        st_d.target = tick_cnt_i + hold_ticks_i;
                    end
                end
            end
            PH_PRESS: begin
                if (!btn_i) begin
                    if (st_q.held) begin
                        st_d.done  = 1'b1;
                        st_d.res   = RES_SINGLE;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.phase  = PH_GAP;
                        st_d.target = tick_cnt_i + gap_ticks_i;
                    end
                end else if (expired) begin
                    st_d.done  = 1'b1;
                    st_d.res   = RES_HOLD;
                    st_d.phase = PH_IDLE;
                end
            end
            PH_GAP: begin
                if (btn_i) begin
                    st_d.done  = 1'b1;
                    st_d.res   = RES_DOUBLE;
                    st_d.phase = PH_IDLE;
                end else if (expired) begin
                    st_d.done  = 1'b1;
                    st_d.res   = RES_SINGLE;
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.done  = 1'b1;
                st_d.res   = RES_ERR;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.held   <= 1'b0;
            st_q.target <= '0;
            st_q.done   <= 1'b0;
            st_q.res    <= RES_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign result_o    = st_q.res;
    assign busy_o      = (st_q.phase != PH_IDLE);
    assign gap_o       = (st_q.phase == PH_GAP);
    assign held_mode_o = st_q.held;
endmodule

// File: rtl/btn_click_classifier.sv
module btn_click_classifier #(
    parameter int PRESCALE   = 1024,
    parameter int CNT_W      = 16,
    parameter int MS_W       = 16,
    parameter int TICK_NUM   = 48000,
    parameter int TICK_SHIFT = 10,
    parameter int DEFAULT_MS = 1000,
    parameter int GAP_MS     = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            btn_i,
    input  logic            start_i,
    input  logic            mode_held_i,
    input  logic [MS_W-1:0] hold_ms_i,
    output logic            done_o,
    output logic [2:0]      result_o
);
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] hold_ticks;
    logic [CNT_W-1:0] gap_ticks;
    logic             busy;
    logic             in_gap;
    logic             held_mode;

    btn_cls_timebase #(
        .PRESCALE (PRESCALE),
        .CNT_W    (CNT_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_cnt_o (tick_cnt)
    );

    btn_cls_window #(
        .TICK_NUM   (TICK_NUM),
        .TICK_SHIFT (TICK_SHIFT),
        .DEFAULT_MS (DEFAULT_MS),
        .GAP_MS     (GAP_MS),
        .MS_W       (MS_W),
        .CNT_W      (CNT_W)
    ) u_window (
        .hold_ms_i    (hold_ms_i),
        .hold_ticks_o (hold_ticks),
        .gap_ticks_o  (gap_ticks)
    );

    btn_cls_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .btn_i        (btn_i),
        .mode_held_i  (mode_held_i),
        .hold_ticks_i (hold_ticks),
        .gap_ticks_i  (gap_ticks),
        .tick_cnt_i   (tick_cnt),
        .done_o       (done_o),
        .result_o     (result_o),
        .busy_o       (busy),
        .gap_o        (in_gap),
        .held_mode_o  (held_mode)
    );
endmodule

// File: rtl/btn_cls_checker.sv
module btn_cls_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             btn_i,
    input logic             start_i,
    input logic             done_o,
    input logic [2:0]       result_o,
    input logic [CNT_W-1:0] tick_cnt,
    input logic             busy,
    input logic             in_gap,
    input logic             held_mode
);
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt != $past(tick_cnt)) |-> (tick_cnt == CNT_W'($past(tick_cnt) + 1'b1)));

    p_noclick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && !btn_i) |=> (done_o && result_o == 3'd0));

    p_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && btn_i) |=> (done_o && result_o == 3'd2));

    p_heldonly_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_gap && held_mode && !btn_i) |=> (done_o && result_o == 3'd1));

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy) || $past(start_i && !btn_i)));

    p_idle_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

bind btn_click_classifier btn_cls_checker #(.CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_i     (btn_i),
    .start_i   (start_i),
    .done_o    (done_o),
    .result_o  (result_o),
    .tick_cnt  (tick_cnt),
    .busy      (busy),
    .in_gap    (in_gap),
    .held_mode (held_mode)
);

// File: tb/btn_click_classifier_tb_top.sv
module btn_click_classifier_tb_top;
    localparam int PRE    = 4;
    localparam int CW     = 10;
    localparam int MOD    = 1 << CW;
    localparam int DEF_MS = 8;
    localparam int GAP_MS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] ms = 16'd0;
    logic        done_o;
    logic [2:0]  result_o;

    int vectors = 0;
    int miscmp  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    btn_click_classifier #(
        .PRESCALE   (PRE),
        .CNT_W      (CW),
        .MS_W       (16),
        .TICK_NUM   (48000),
        .TICK_SHIFT (10),
        .DEFAULT_MS (DEF_MS),
        .GAP_MS     (GAP_MS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_i       (btn),
        .start_i     (start),
        .mode_held_i (mode),
        .hold_ms_i   (ms),
        .done_o      (done_o),
        .result_o    (result_o)
    );

    function automatic int win_ticks(int m);
        longint e;
        e = (m == 0) ? DEF_MS : m;
        return int'(((48000 * e) >> 10) % MOD);
    endfunction

    // ---------------- behavioural reference model ----------------
    int    m_cyc, m_state, m_deadline;
    bit    m_held;
    bit    exp_done;
    int    exp_res;
    string exp_tag = "R1";
    int    tb_cyc = 0;

    always @(posedge clk) begin
        tb_cyc = tb_cyc + 1;
        if (!rst_n) begin
            m_cyc = 0; m_state = 0; m_deadline = 0; m_held = 0;
            exp_done = 0; exp_res = 0;
        end else begin
            int cur;
            cur = (m_cyc / PRE) % MOD;
            exp_done = 0;
            if (m_state == 0) begin
                if (start) begin
                    if (!btn) begin
                        exp_done = 1; exp_res = 0; exp_tag = "R3";
                    end else begin
                        m_state = 1; m_held = mode;
                        m_deadline = (cur + win_ticks(int'(ms))) % MOD;
                    end
                end
            end else if (m_state == 1) begin
                if (!btn) begin
                    if (m_held) begin
                        exp_done = 1; exp_res = 1; exp_tag = "R7"; m_state = 0;
                    end else begin
                        m_state = 2;
                        m_deadline = (cur + win_ticks(GAP_MS)) % MOD;
                    end
                end else if (cur == m_deadline) begin
                    exp_done = 1; exp_res = 3; m_state = 0;
                    exp_tag = m_held ? "R7" : "R4";
                end
            end else begin
                if (btn) begin
                    exp_done = 1; exp_res = 2; exp_tag = "R6"; m_state = 0;
                end else if (cur == m_deadline) begin
                    exp_done = 1; exp_res = 1; exp_tag = "R5"; m_state = 0;
                end
            end
            m_cyc = m_cyc + 1;
        end
    end

    // per-cycle comparison and result monitor
    int last_res = -1;
    int n_done = 0;
    int done_cyc = 0;
    int run = 0;
    int max_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            vectors = vectors + 1;
            if (done_o !== exp_done || int'(result_o) !== exp_res) begin
                miscmp = miscmp + 1;
                $display("FAIL %s (R9 timing model) cycle %0d: done=%0b result=%0d expected done=%0b result=%0d",
                         exp_tag, tb_cyc, done_o, result_o, exp_done, exp_res);
            end
            if (done_o) begin
                last_res = int'(result_o);
                n_done   = n_done + 1;
                done_cyc = tb_cyc;
                run      = run + 1;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        vectors = vectors + 1;
        if (got != exp) begin
            miscmp = miscmp + 1;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input bit md, input int dur);
        @(negedge clk);
        start = 1'b1; mode = md; ms = 16'(dur);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscmp = miscmp + 1;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int nd;
        int t0;
        idle(3);
        chk("R1 done in reset", int'(done_o), 0);
        chk("R1 result in reset", int'(result_o), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 result after reset", int'(result_o), 0);

        // R3: start with button up
        nd = n_done;
        btn = 1'b0; kick(1'b0, 2); idle(3);
        chk("R3 no-click code", last_res, 0);
        chk("R3 one done", n_done - nd, 1);

        // R4: click mode, hold through window
        btn = 1'b1; kick(1'b0, 2); idle(400);
        chk("R4 hold code", last_res, 3);
        btn = 1'b0; idle(5);

        // R5: click then wait out post-release window
        btn = 1'b1; kick(1'b0, 2); idle(50);
        btn = 1'b0; idle(20);
        chk("R5 no result yet", last_res, 3);
        idle(800);
        chk("R5 single code", last_res, 1);

        // R6: double click, then R10 result holds
        btn = 1'b1; kick(1'b0, 2); idle(50);
        btn = 1'b0; idle(200);
        btn = 1'b1; idle(5);
        chk("R6 double code", last_res, 2);
        btn = 1'b0; idle(10);
        chk("R10 result held", int'(result_o), 2);

        // R7: held-only mode
        btn = 1'b1; kick(1'b1, 2); idle(50);
        btn = 1'b0; idle(3);
        chk("R7 early release single", last_res, 1);
        btn = 1'b1; kick(1'b1, 2); idle(400);
        chk("R7 held-only hold", last_res, 3);
        btn = 1'b0; idle(5);

        // R2: default duration when ms = 0
        btn = 1'b1;
        @(negedge clk); t0 = tb_cyc;
        start = 1'b1; mode = 1'b0; ms = 16'd0;
        @(negedge clk); start = 1'b0;
        idle(1600);
        chk("R2 default hold code", last_res, 3);
        chk("R2 default window length", ((done_cyc - t0) >= 1496 && (done_cyc - t0) <= 1506) ? 1 : 0, 1);
        btn = 1'b0; idle(5);

        // R8: extra start while busy is ignored
        btn = 1'b1; kick(1'b0, 2); idle(20);
        nd = n_done;
        kick(1'b1, 0); idle(20);
        btn = 1'b0; idle(3);
        chk("R8 release still click mode", n_done - nd, 0);
        idle(800);
        chk("R8 single after ignored start", last_res, 1);
        chk("R8 one done", n_done - nd, 1);

        // R9: repeated default holds span the count wrap
        for (int i = 0; i < 4; i++) begin
            btn = 1'b1; kick(1'b0, 0); idle(1550);
            chk("R9 hold across wrap", last_res, 3);
            btn = 1'b0; idle(7);
        end

        chk("R10 done width", max_run, 1);
        idle(5);
        finish_run();
    end
endmodule